// File: doc/BRIEF.md
# Unaligned Wide Instruction Fetch Unit

This block supplies an execution core with a four-byte window of code that starts at any byte address. The code store is addressed by byte and read four bytes at a time. Inside the block it is split into four byte-wide lane banks. For each fetch, every lane bank receives its own word index, so a window that crosses a word boundary is read in a single access. The lane outputs are then rotated so that byte 0 of the window is the byte at the fetch address. As a result, an instruction of one, two or three bytes, and the first byte of the following instruction, all arrive in the same cycle.

An external decoder examines the window and returns a two-bit length code. The fetch address for the next cycle is the current address plus the decoded length. This sum comes from one adder as wide as the program counter. The fetch of the next window therefore overlaps execution of the current instruction, and one window is delivered per cycle. A jump port loads a new program counter. A stall input freezes the unit. A byte-wide write port fills the code store.

Top module: `wide_fetch`

## Requirements
- R1: While rstN is low, winValid is 0 and winAddr is 0.
- R2: When winValid is 1, bits [8j+7:8j] of winData hold the stored byte at address winAddr+j, for j = 0..3, whatever the value of winAddr[1:0].
- R3: In a cycle where winValid is 1 and neither stall nor jmpEn is high, winAddr advances by lenCode+1 in the next cycle (code 0 = 1 byte, 1 = 2, 2 = 3, 3 = 4 bytes).
- R4: jmpEn takes priority over lenCode. After a cycle with jmpEn high and stall low, the next cycle shows winValid = 1, winAddr = jmpAddr, and the window of the target.
- R5: A cycle with stall high leaves winAddr, winData and winValid unchanged in the next cycle, even when jmpEn or lenCode is active.
- R6: winAddr wraps modulo 65536. A window starting at 0xFFFD or above takes its later bytes from address 0 onward.
- R7: Byte address a is held in the store at a mod 2^STORE_AW, and a write stored in the store through wrEn/wrAddr/wrData appears in every later window that covers that address.
- R8: While winValid is 0, lenCode has no effect. The first cycle out of reset with stall and jmpEn low gives a valid window at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Holds the program counter and the window |
| jmpEn | input | 1 | Loads jmpAddr as the next fetch address |
| jmpAddr | input | 16 | Jump target byte address |
| lenCode | input | 2 | Length of the current instruction minus one |
| wrEn | input | 1 | Code store byte write strobe |
| wrAddr | input | 16 | Code store write byte address |
| wrData | input | 8 | Code store write byte |
| winValid | output | 1 | Window holds fetched code |
| winAddr | output | 16 | Byte address of window byte 0 (program counter) |
| winData | output | 32 | Four consecutive code bytes, byte 0 in bits 7:0 |

## Verification
The bench steps through every length code from all four byte offsets. Placing a window across a word boundary catches a lane that was given the wrong word index: such a design would repeat bytes from the current word instead of taking them from the next one. Windows are also placed across the end of the store and across 0xFFFF. There, a missing wrap would return bytes from beyond the store, or would leave the program counter at the wrong address. A jump issued together with a length, and a jump issued during a stall, test the priority order: a wrong order would land at pc+length, or would move during the stall. A byte written while the unit is stalled must appear in the window of a later jump, and the first cycle after reset must ignore the length code.

// File: rtl/wide_fetch_pkg.sv
package wide_fetch_pkg;
  parameter int PC_W = 16;

  typedef logic [PC_W-1:0] pc_t;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic rdEn;      // read the lane banks this cycle
    pc_t  fetchAddr; // byte address of the window to fetch
  } fetch_cmd_t;
endpackage

// File: rtl/wide_fetch_bank.sv
module wide_fetch_bank #(
  parameter int WORD_AW = 8
) (
  input  logic               clk,
  input  logic               rdEn,
  input  logic [WORD_AW-1:0] rdIdx,
  output logic [7:0]         rdByte,
  input  logic               wrEn,
  input  logic [WORD_AW-1:0] wrIdx,
  input  logic [7:0]         wrByte
);
  localparam int DEPTH = 1 << WORD_AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrIdx] <= wrByte;
    if (rdEn) rdByte <= mem[rdIdx];
  end
endmodule

// File: rtl/wide_fetch_ctrl.sv
module wide_fetch_ctrl
  import wide_fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stall,
  input  logic       jmpEn,
  input  pc_t        jmpAddr,
  input  logic [1:0] lenCode,
  output fetch_cmd_t cmd,
  output pc_t        pcOut,
  output logic       validOut
);
  pc_t        pcReg;
  logic       validReg;
  logic [2:0] step;
  pc_t        sumPc;
  pc_t        nextPc;

  // A single full-width adder. The step is zero until the first window exists.
  always_comb begin
    step  = validReg ? ({1'b0, lenCode} + 3'd1) : 3'd0;
    sumPc = pcReg + pc_t'(step);
  end

  // Priority order: stall, then jump, then length.
  always_comb begin
    if (stall)      nextPc = pcReg;
    else if (jmpEn) nextPc = jmpAddr;
    else            nextPc = sumPc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg    <= '0;
      validReg <= 1'b0;
    end else if (!stall) begin
      pcReg    <= nextPc;
      validReg <= 1'b1;
    end
  end

  always_comb begin
    cmd.rdEn      = !stall;
    cmd.fetchAddr = nextPc;
  end

  assign pcOut    = pcReg;
  assign validOut = validReg;
endmodule

// File: rtl/wide_fetch_dp.sv
module wide_fetch_dp
  import wide_fetch_pkg::*;
#(
  parameter int STORE_AW = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  fetch_cmd_t cmd,
  input  logic       wrEn,
  input  pc_t        wrAddr,
  input  logic [7:0] wrData,
  output logic [31:0] winData
);
  localparam int WORD_AW = STORE_AW - 2;
  localparam int LANES   = 4;

  logic [WORD_AW-1:0] baseIdx;
  logic [WORD_AW-1:0] nextIdx;
  logic [1:0]         rdOff;
  logic [1:0]         offReg;
  logic [7:0]         laneByte [LANES];

  assign baseIdx = cmd.fetchAddr[STORE_AW-1:2];
  assign nextIdx = baseIdx + 1'b1;
  assign rdOff   = cmd.fetchAddr[1:0];

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [WORD_AW-1:0] laneIdx;
      logic               laneWr;

      // Lanes below the start offset belong to the following word.
      assign laneIdx = (2'(k) >= rdOff) ? baseIdx : nextIdx;
      assign laneWr  = wrEn && (wrAddr[1:0] == 2'(k));

      wide_fetch_bank #(.WORD_AW(WORD_AW)) u_bank (
        .clk    (clk),
        .rdEn   (cmd.rdEn),
        .rdIdx  (laneIdx),
        .rdByte (laneByte[k]),
        .wrEn   (laneWr),
        .wrIdx  (wrAddr[STORE_AW-1:2]),
        .wrByte (wrData)
      );
    end
  endgenerate

  // The rotate amount is registered alongside the bank read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         offReg <= 2'd0;
    else if (cmd.rdEn) offReg <= rdOff;
  end

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      winData[8*j +: 8] = laneByte[2'(offReg + 2'(j))];
    end
  end
endmodule

// File: rtl/wide_fetch.sv
module wide_fetch
  import wide_fetch_pkg::*;
#(
  parameter int STORE_AW = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        stall,
  input  logic        jmpEn,
  input  logic [15:0] jmpAddr,
  input  logic [1:0]  lenCode,
  input  logic        wrEn,
  input  logic [15:0] wrAddr,
  input  logic [7:0]  wrData,
  output logic        winValid,
  output logic [15:0] winAddr,
  output logic [31:0] winData
);
  fetch_cmd_t cmd;

  wide_fetch_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stall    (stall),
    .jmpEn    (jmpEn),
    .jmpAddr  (jmpAddr),
    .lenCode  (lenCode),
    .cmd      (cmd),
    .pcOut    (winAddr),
    .validOut (winValid)
  );

  wide_fetch_dp #(.STORE_AW(STORE_AW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .winData (winData)
  );
endmodule

// File: rtl/wide_fetch_chk.sv
module wide_fetch_chk (
  input logic        clk,
  input logic        rstN,
  input logic        stall,
  input logic        jmpEn,
  input logic [15:0] jmpAddr,
  input logic [1:0]  lenCode,
  input logic        winValid,
  input logic [15:0] winAddr,
  input logic [31:0] winData
);
  // R3: a length step moves the program counter by lenCode+1, modulo 2^16 (R6)
  a_r3_len_step: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && !stall && !jmpEn) |=>
      (winAddr == 16'($past(winAddr) + 16'($past(lenCode)) + 16'd1)));

  // R4: a jump wins over the length and is valid one cycle later
  a_r4_jump: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && jmpEn) |=> (winValid && winAddr == $past(jmpAddr)));

  // R5: stall freezes the whole visible state
  a_r5_stall: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(winAddr) && $stable(winData) && $stable(winValid)));

  // R8: the first window after reset starts where the counter stands
  a_r8_first: assert property (@(posedge clk) disable iff (!rstN)
    (!winValid && !stall && !jmpEn) |=> (winValid && winAddr == $past(winAddr)));

  // R1: once valid, the window stays valid until the next reset
  a_r1_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    winValid |=> winValid);
endmodule

bind wide_fetch wide_fetch_chk u_chk (.*);

// File: tb/wide_fetch_bench.sv
module wide_fetch_bench;
  localparam int STORE_AW = 10;
  localparam int STORE_SZ = 1 << STORE_AW;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stall = 1'b0;
  logic        jmpEn = 1'b0;
  logic [15:0] jmpAddr = '0;
  logic [1:0]  lenCode = '0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        winValid;
  logic [15:0] winAddr;
  logic [31:0] winData;

  always #5 clk = ~clk;

  wide_fetch #(.STORE_AW(STORE_AW)) u_wide_fetch (.*);

  typedef struct {
    logic        valid;
    logic [15:0] addr;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  int          checkCnt = 0;
  int          failCnt = 0;
  logic [7:0]  mem [STORE_SZ];
  logic        mValid = 1'b0;
  logic [15:0] mPc = '0;
  logic [31:0] mData = '0;

  function automatic logic [7:0] pat(int i);
    return 8'(i * 37 + 11);
  endfunction

  function automatic logic [31:0] window(logic [15:0] a);
    logic [31:0] w;
    for (int j = 0; j < 4; j++) begin
      w[8*j +: 8] = mem[STORE_AW'(16'(a + 16'(j)))];
    end
    return w;
  endfunction

  task automatic report(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle's inputs at the current time and queue the model result.
  task automatic apply(logic st, logic je, logic [15:0] ja, logic [1:0] ln, string tag);
    exp_t e;
    stall   = st;
    jmpEn   = je;
    jmpAddr = ja;
    lenCode = ln;
    if (!st) begin
      if (je)          mPc = ja;
      else if (mValid) mPc = 16'(mPc + 16'(ln) + 16'd1);
      mValid = 1'b1;
      mData  = window(mPc);
    end
    e.valid = mValid;
    e.addr  = mPc;
    e.data  = mData;
    e.tag   = tag;
    expQ.push_back(e);
  endtask

  task automatic step(logic st, logic je, logic [15:0] ja, logic [1:0] ln, string tag);
    @(negedge clk);
    wrEn = 1'b0;
    apply(st, je, ja, ln, tag);
  endtask

  // Monitor: one expected item per clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() != 0) begin
        exp_t e;
        e = expQ.pop_front();
        report(e.tag, "winValid", 32'(winValid), 32'(e.valid));
        report(e.tag, "winAddr", 32'(winAddr), 32'(e.addr));
        if (e.valid) report(e.tag, "winData", winData, e.data);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    // Fill the store during reset (R7)
    for (int i = 0; i < STORE_SZ; i++) begin
      @(negedge clk);
      wrEn   = 1'b1;
      wrAddr = 16'(i);
      wrData = pat(i);
      mem[i] = pat(i);
    end
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
    report("R1", "winValid in reset", 32'(winValid), 32'd0);
    report("R1", "winAddr in reset", 32'(winAddr), 32'd0);

    // R8: release reset with a non-zero length that must be ignored
    rstN = 1'b1;
    apply(1'b0, 1'b0, 16'h0, 2'd3, "R8");

    // R3 / R2: every length code from varied offsets
    step(1'b0, 1'b0, 16'h0, 2'd0, "R3");
    step(1'b0, 1'b0, 16'h0, 2'd1, "R3");
    step(1'b0, 1'b0, 16'h0, 2'd2, "R3");
    step(1'b0, 1'b0, 16'h0, 2'd3, "R3");
    step(1'b0, 1'b0, 16'h0, 2'd0, "R2");

    // R5: stall with a length, then stall with a jump
    step(1'b1, 1'b0, 16'h0, 2'd2, "R5");
    step(1'b1, 1'b1, 16'h0200, 2'd1, "R5");

    // R4: jump together with a length
    step(1'b0, 1'b1, 16'h0123, 2'd3, "R4");
    step(1'b0, 1'b0, 16'h0, 2'd1, "R2");

    // R7: write while stalled, then jump over the written byte
    @(negedge clk);
    apply(1'b1, 1'b0, 16'h0, 2'd0, "R5");
    wrEn   = 1'b1;
    wrAddr = 16'h0130;
    wrData = 8'hA5;
    mem[16'h0130] = 8'hA5;
    step(1'b0, 1'b1, 16'h012F, 2'd0, "R7");

    // R6: wrap across 0xFFFF
    step(1'b0, 1'b1, 16'hFFFE, 2'd0, "R6");
    step(1'b0, 1'b0, 16'h0, 2'd3, "R6");
    step(1'b0, 1'b1, 16'hFFFF, 2'd0, "R6");
    step(1'b0, 1'b0, 16'h0, 2'd0, "R6");

    // R7: end of store and an aliased address
    step(1'b0, 1'b1, 16'h03FE, 2'd0, "R7");
    step(1'b0, 1'b1, 16'h1405, 2'd2, "R7");
    step(1'b0, 1'b0, 16'h0, 2'd2, "R7");

    // R2: mixed traffic
    for (int i = 0; i < 60; i++) begin
      step((i % 7) == 3, (i % 11) == 5, 16'(i * 1237), 2'(i), "R2");
    end

    @(negedge clk);
    stall = 1'b1;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule